// File: doc/BRIEF.md
# Split Decade Counter with Selectable Chaining

This block is a four-bit decade counter made of two halves, each with its own count input. One half is a divide-by-two stage that owns output bit 0. The other half is a divide-by-five stage that owns output bits 3..1 and steps through the values 0 to 4 and then back to 0. A chaining select decides how the halves are joined. In BCD chaining, the carry from bit 0 drives the five-stage, so the output counts 0 to 9 in plain binary. In bi-quinary chaining, the carry from bit 3 drives the two-stage, so bit 0 is a square wave at one tenth of the input rate.

All logic runs on one free-running system clock. The two count inputs are sampled on that clock, and a falling edge is recognised when the previous sample was 1 and the current sample is 0. An internal carry acts in the same cycle as the external edge that caused it. An active-low clear and an active-low load take effect on the first clock edge at which they are sampled low. This stands in for the asynchronous behaviour of a discrete part. While load is held low, the output follows the data bus like a transparent latch, one register stage behind it. The edge history keeps updating during an override, so releasing clear or load never produces a count on its own.

Top module: `split_decade_counter`

## Requirements
- R1: When `clr_n` is sampled low at a rising clock edge, `q` is 0000 after that edge, whatever `load_n`, `din` and the count inputs are doing.
- R2: When `load_n` is sampled low and `clr_n` is high, `q` equals the `din` sampled at that edge. While `load_n` stays low, a change on `din` appears on `q` one clock later.
- R3: While `clr_n` or `load_n` is low, falling edges on `cnt_a` and `cnt_b` do not change `q`. Releasing the override does not cause a count.
- R4: With `chain_sel`=0 (BCD), a falling edge on `cnt_a` advances `q` through binary 0 to 9 and then back to 0. The edge is seen at the first rising clock edge that samples the input low after a high sample, and `q` changes on the next rising clock edge.
- R5: With `chain_sel`=0, falling edges on `cnt_b` have no effect on `q`.
- R6: With `chain_sel`=1 (bi-quinary), each falling edge on `cnt_b` (same latency as R4) steps {q[0],q[3],q[2],q[1]} through 0000, 0001, 0010, 0011, 0100, 1000, 1001, 1010, 1011, 1100 and then repeats. `q[0]` is therefore high for exactly 5 of every 10 input edges.
- R7: With `chain_sel`=1, falling edges on `cnt_a` have no effect on `q`.
- R8: If the five-stage holds 5, 6 or 7 (q[3:1] = 101, 110 or 111), its next step is to 000. That step counts as bit 3 falling, so in bi-quinary chaining it also toggles `q[0]`.
- R9: When the synchronous system reset `rst` is high, `q` is 0000 after the edge and the edge history is cleared.
- R10: After a load is released, counting continues from the loaded value. For example, 0111 loaded in BCD chaining becomes 1000 on the next `cnt_a` falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high system reset |
| chain_sel | input | 1 | 0 = BCD chaining, 1 = bi-quinary chaining |
| cnt_a | input | 1 | Count input of the divide-by-two stage (falling edge active) |
| cnt_b | input | 1 | Count input of the divide-by-five stage (falling edge active) |
| clr_n | input | 1 | Active-low clear, highest functional priority |
| load_n | input | 1 | Active-low transparent load |
| din | input | 4 | Load data, bit 0 to the two-stage and bits 3..1 to the five-stage |
| q | output | 4 | Counter state, registered |

## Verification
A wrong state in either stage is visible on `q` at once, because every state bit is an output. A carry that is lost or doubled shows up within one input edge. In BCD chaining it appears as a skipped or repeated value next to the 9-to-0 wrap. In bi-quinary chaining it appears as a `q[0]` toggle at the wrong place or a missing one, which moves the 5-of-10 duty count. Wrong override priority shows on the clock edge after `clr_n` or `load_n` falls. A false count on release shows one clock after the release.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int unsigned TWO_W  = 1;
  localparam int unsigned FIVE_W = 3;
  localparam int unsigned Q_W    = TWO_W + FIVE_W;
  localparam logic [FIVE_W-1:0] FIVE_LAST = FIVE_W'(4);

  typedef enum logic { CHAIN_BCD = 1'b0, CHAIN_BIQ = 1'b1 } chain_e;
  typedef enum logic [1:0] { OVR_NONE = 2'd0, OVR_CLEAR = 2'd1, OVR_LOAD = 2'd2 } ovr_e;

  // Divide-by-five successor: 0..3 step up, 4 and any illegal state go to 0
  function automatic logic [FIVE_W-1:0] five_succ(input logic [FIVE_W-1:0] v);
    return (v >= FIVE_LAST) ? '0 : v + FIVE_W'(1);
  endfunction
endpackage

// File: rtl/sdc_fall_detect.sv
module sdc_fall_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig_in,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic cur_r, old_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        cur_r <= 1'b0;
        old_r <= 1'b0;
      end else begin
        cur_r <= sig_in[i];
        old_r <= cur_r;
      end
    end
    assign fall[i] = old_r & ~cur_r;
  end
endmodule

// File: rtl/sdc_stage.sv
module sdc_stage
  import sdc_pkg::*;
#(
  parameter int unsigned W      = 1,
  parameter bit          IS_FIVE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  ovr_e         ovr,
  input  logic [W-1:0] ld_val,
  input  logic         tick,
  output logic [W-1:0] val
);
  logic [W-1:0] nxt;

  if (IS_FIVE) begin : g_five
    always_comb nxt = W'(five_succ(FIVE_W'(val)));
  end else begin : g_two
    always_comb nxt = val + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
    end else begin
      unique case (ovr)
        OVR_CLEAR: val <= '0;
        OVR_LOAD:  val <= ld_val;
        default:   if (tick) val <= nxt;
      endcase
    end
  end
endmodule

// File: rtl/split_decade_counter.sv
module split_decade_counter
  import sdc_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           chain_sel,
  input  logic           cnt_a,
  input  logic           cnt_b,
  input  logic           clr_n,
  input  logic           load_n,
  input  logic [Q_W-1:0] din,
  output logic [Q_W-1:0] q
);
  logic [1:0]        fall;
  logic              tick_a, tick_b;
  ovr_e              ovr;
  chain_e            chain;
  logic [TWO_W-1:0]  two_v;
  logic [FIVE_W-1:0] five_v;

  sdc_fall_detect #(.N(2)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_in ({cnt_b, cnt_a}),
    .fall   (fall)
  );

  assign chain = chain_e'(chain_sel);

  always_comb begin
    if (!clr_n)       ovr = OVR_CLEAR;
    else if (!load_n) ovr = OVR_LOAD;
    else              ovr = OVR_NONE;
  end

  // Carries are formed from stage state and the external edge only,
  // so the two chaining choices never form a combinational loop.
  always_comb begin
    if (chain == CHAIN_BCD) begin
      tick_a = fall[0];
      tick_b = fall[0] & two_v[0];
    end else begin
      tick_b = fall[1];
      tick_a = fall[1] & five_v[FIVE_W-1];
    end
  end

  sdc_stage #(.W(TWO_W), .IS_FIVE(1'b0)) u_two (
    .clk    (clk),
    .rst    (rst),
    .ovr    (ovr),
    .ld_val (din[TWO_W-1:0]),
    .tick   (tick_a),
    .val    (two_v)
  );

  sdc_stage #(.W(FIVE_W), .IS_FIVE(1'b1)) u_five (
    .clk    (clk),
    .rst    (rst),
    .ovr    (ovr),
    .ld_val (din[Q_W-1:TWO_W]),
    .tick   (tick_b),
    .val    (five_v)
  );

  assign q = {five_v, two_v};
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
  input logic       clk,
  input logic       rst,
  input logic       chain_sel,
  input logic       clr_n,
  input logic       load_n,
  input logic [3:0] din,
  input logic       tick_a,
  input logic       tick_b,
  input logic [3:0] q
);
  assert_sysreset_R9: assert property (@(posedge clk) rst |=> (q == 4'd0));

  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (q == 4'd0));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> (q == $past(din)));

  assert_bcd_step_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !chain_sel && tick_a && q <= 4'd8) |=> (q == $past(q) + 4'd1));

  assert_bcd_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !chain_sel && tick_a && q == 4'd9) |=> (q == 4'd0));

  assert_bcd_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !chain_sel && !tick_a) |=> $stable(q));

  assert_biq_half_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && chain_sel && tick_b && q[3]) |=>
      ((q[0] != $past(q[0])) && (q[3:1] == 3'b000)));

  assert_biq_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && chain_sel && !tick_b) |=> $stable(q));
endmodule

bind split_decade_counter sdc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .chain_sel (chain_sel),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .din       (din),
  .tick_a    (tick_a),
  .tick_b    (tick_b),
  .q         (q)
);

// File: tb/tb_split_decade_counter.sv
module tb_split_decade_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chain_sel = 1'b0;
  logic       cnt_a = 1'b1;
  logic       cnt_b = 1'b1;
  logic       clr_n = 1'b1;
  logic       load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic [3:0] q;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  string phase = "R9";

  // behavioural reference state
  int m_two = 0, m_five = 0;
  int ha1 = 0, ha2 = 0, hb1 = 0, hb2 = 0;

  split_decade_counter dut (
    .clk(clk), .rst(rst), .chain_sel(chain_sel), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .clr_n(clr_n), .load_n(load_n), .din(din), .q(q)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    int fa, fb;
    fa = (ha2 == 1 && ha1 == 0) ? 1 : 0;
    fb = (hb2 == 1 && hb1 == 0) ? 1 : 0;
    if (rst) begin
      m_two = 0; m_five = 0; ha1 = 0; ha2 = 0; hb1 = 0; hb2 = 0;
    end else begin
      if (!clr_n) begin
        m_two = 0; m_five = 0;
      end else if (!load_n) begin
        m_two = din[0]; m_five = din[3:1];
      end else if (!chain_sel) begin
        if (fa == 1) begin
          if (m_two == 1) begin
            m_two = 0;
            m_five = (m_five >= 4) ? 0 : m_five + 1;
          end else m_two = 1;
        end
      end else if (fb == 1) begin
        if (m_five >= 4) begin
          m_five = 0;
          m_two = 1 - m_two;
        end else m_five = m_five + 1;
      end
      ha2 = ha1; ha1 = cnt_a;
      hb2 = hb1; hb1 = cnt_b;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] e;
      e = {3'(m_five), 1'(m_two)};
      n_cmp++;
      if (q !== e) begin
        n_bad++;
        $display("FAIL %s model compare: got %b expected %b at %0t", phase, q, e, $time);
      end
    end
  end

  task automatic check(input string tag, input logic [3:0] exp);
    n_cmp++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, q, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a();
    cnt_a = 1'b0; cyc(2); cnt_a = 1'b1; cyc(2);
  endtask

  task automatic pulse_b();
    cnt_b = 1'b0; cyc(2); cnt_b = 1'b1; cyc(2);
  endtask

  task automatic do_load(input logic [3:0] v);
    din = v; load_n = 1'b0; cyc(1); load_n = 1'b1; cyc(1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] biq_seq [10];
    int highs;
    biq_seq = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100,
                4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b1100};
    cyc(3);
    check("R9 reset state", 4'd0);
    rst = 1'b0; cyc(2);

    // R1: clear beats load
    phase = "R1";
    do_load(4'b0110);
    din = 4'b1111; clr_n = 1'b0; load_n = 1'b0; cyc(1);
    check("R1 clear over load", 4'd0);
    clr_n = 1'b1; cyc(1);
    check("R2 load after clear", 4'b1111);

    // R2: transparent load
    phase = "R2";
    din = 4'b0101; cyc(1);
    check("R2 load follows din", 4'b0101);
    din = 4'b1010; cyc(1);
    check("R2 load follows din change", 4'b1010);

    // R3: edges ignored during override, no count on release
    phase = "R3";
    pulse_a(); pulse_b();
    check("R3 edges ignored in load", 4'b1010);
    cnt_a = 1'b0; cyc(2);
    load_n = 1'b1; cyc(3);
    check("R3 no count on release", 4'b1010);
    cnt_a = 1'b1; cyc(2);
    clr_n = 1'b0; pulse_a(); clr_n = 1'b1; cyc(2);
    check("R3 edges ignored in clear", 4'd0);

    // R4: BCD counting with wrap
    phase = "R4";
    chain_sel = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      pulse_a();
      check("R4 BCD step", 4'(i % 10));
    end

    // R5: cnt_b ignored in BCD
    phase = "R5";
    pulse_b(); pulse_b();
    check("R5 cnt_b ignored in BCD", 4'd2);

    // R10: resume from loaded value
    phase = "R10";
    do_load(4'b0111);
    pulse_a();
    check("R10 resume after load", 4'b1000);

    // R8 in BCD: five-stage illegal value
    phase = "R8";
    do_load(4'b1110);
    pulse_a();
    check("R8 BCD 1110 to 1111", 4'b1111);
    pulse_a();
    check("R8 BCD illegal five-stage to 000", 4'b0000);

    // R6: bi-quinary sequence and duty
    phase = "R6";
    chain_sel = 1'b1;
    clr_n = 1'b0; cyc(1); clr_n = 1'b1; cyc(1);
    highs = 0;
    for (int i = 1; i <= 12; i++) begin
      logic [3:0] s;
      pulse_b();
      s = biq_seq[i % 10];
      check("R6 bi-quinary step", {s[2:0], s[3]});
      if (i <= 10 && q[0]) highs++;
    end
    n_cmp++;
    if (highs != 5) begin
      n_bad++;
      $display("FAIL R6 duty: got %0d expected 5", highs);
    end

    // R7: cnt_a ignored in bi-quinary
    phase = "R7";
    pulse_a(); pulse_a();
    check("R7 cnt_a ignored in bi-quinary", 4'b0100);

    // R8 in bi-quinary: 101 in five-stage wraps and toggles q[0]
    phase = "R8";
    do_load(4'b1010);
    pulse_b();
    check("R8 bi-quinary illegal wrap toggles q0", 4'b0001);

    // R9: system reset mid-run
    phase = "R9";
    pulse_b();
    rst = 1'b1; cyc(1);
    check("R9 reset mid-run", 4'd0);
    rst = 1'b0; cyc(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule